// File: doc/BRIEF.md
# Internal Data Space Router

This block sits between an 8-bit controller core and its internal data space. Every core access carries a byte address and a flag telling whether the address came from an indirect pointer or straight from the instruction. The block steers the access to one of three places: the lower half of the on-chip RAM, the upper half of the RAM, or an external bus to the special function registers. It also returns the read data.

The lower 128 addresses always reach the lower RAM. The upper 128 addresses are shared by two stores that are physically separate. A direct access to one of them reaches the register bus. An indirect access reaches the upper RAM. Stack traffic is issued as indirect accesses, so the stack can live in the upper RAM without disturbing any register.

The set of register addresses that exist is a parameter list. Any address in the upper half that is not on the list reads as zero, and writes to it are discarded. RAM reads and register reads return their data after the same one-cycle latency. The core can therefore treat both paths alike.

Top module: `idata_router`

## Requirements
- R1: An access whose address bit 7 is 0 goes to the lower RAM in either addressing mode. It never raises `sfr_sel`, `sfr_rd` or `sfr_wr`. Data written in one mode reads back in the other.
- R2: A direct access (`acc_indirect`=0) to an address of 80H or above that is on the implemented list drives the register bus in the same cycle. `sfr_sel` goes high, `sfr_addr` carries the address, `sfr_wdata` carries the write data, and `sfr_rd`/`sfr_wr` follow `acc_rd`/`acc_wr`. RAM is not written.
- R3: An indirect access (`acc_indirect`=1) to an address of 80H or above goes to the upper RAM, including addresses such as A0H that are on the register list. The register bus strobes stay low.
- R4: The upper RAM and the register space are separate stores. A direct write to address X leaves the upper RAM byte at X unchanged, so a later indirect read of X returns the value last written indirectly.
- R5: `rd_valid` is high in exactly the cycle after a cycle with `acc_rd` high, and low otherwise. `rd_data` holds the result in that cycle, for every destination.
- R6: A direct read of an implemented register returns the `sfr_rdata` value present in the request cycle.
- R7: A direct access to an upper address that is not on the implemented list raises no bus strobe and no `sfr_sel`. A read returns 00H, and a write is discarded.
- R8: A read and a write in the same cycle to the same RAM address return the old byte. The new byte is seen by the next read.
- R9: After reset, `rd_valid` is 0, `rd_data` is 00H, and `sfr_sel`, `sfr_rd`, `sfr_wr` are low while no access is requested.
- R10: `rd_data` keeps its last value in cycles that follow a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_addr | input | 8 | Byte address of the access |
| acc_indirect | input | 1 | 1 = indirect/stack access, 0 = direct access |
| acc_rd | input | 1 | Read request |
| acc_wr | input | 1 | Write request |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read result, one cycle after the request |
| rd_valid | output | 1 | High in the cycle `rd_data` carries a new result |
| sfr_sel | output | 1 | Access targets an implemented register |
| sfr_addr | output | 8 | Register address forwarded to the register blocks |
| sfr_rd | output | 1 | Register read strobe |
| sfr_wr | output | 1 | Register write strobe |
| sfr_wdata | output | 8 | Register write data |
| sfr_rdata | input | 8 | Register read data, valid in the request cycle |

## Verification
The register-bus outputs (`sfr_sel`, `sfr_addr`, strobes, write data) depend only on the inputs of the current cycle. The bench checks them shortly after it drives each request, before the next rising edge. `rd_valid` and `rd_data` pass through one register and are due one edge after the request. The bench checks them at the falling edge that follows, before it drives the next access. A reference byte array tracks the expected contents of both RAM halves. This lets the bench predict the read-before-write result and the value held through idle cycles.

// File: rtl/idr_pkg.sv
package idr_pkg;
  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_RAM  = 2'd1,
    DST_SFR  = 2'd2
  } dst_e;
endpackage

// File: rtl/idr_sfr_match.sv
module idr_sfr_match #(
  parameter int ADDR_W = 8,
  parameter int N_SFR  = 4,
  parameter logic [N_SFR*ADDR_W-1:0] SFR_MAP = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [N_SFR-1:0] match;

  for (genvar g = 0; g < N_SFR; g++) begin : g_cmp
    assign match[g] = (addr == SFR_MAP[g*ADDR_W +: ADDR_W]);
  end

  assign hit = |match;
endmodule

// File: rtl/idr_decode.sv
module idr_decode
  import idr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_SFR  = 4,
  parameter logic [N_SFR*ADDR_W-1:0] SFR_MAP = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              indirect,
  output dst_e              dst,
  output logic              sfr_hit
);
  logic upper;
  logic hit;

  idr_sfr_match #(
    .ADDR_W (ADDR_W),
    .N_SFR  (N_SFR),
    .SFR_MAP(SFR_MAP)
  ) u_match (
    .addr(addr),
    .hit (hit)
  );

  assign upper = addr[ADDR_W-1];

  // the upper half is shared: the addressing mode picks the store
  always_comb begin
    if (!upper || indirect) dst = DST_RAM;
    else                    dst = DST_SFR;
  end

  assign sfr_hit = hit && (dst == DST_SFR);
endmodule

// File: rtl/idr_ram_bank.sv
module idr_ram_bank #(
  parameter int DATA_W = 8,
  parameter int AW     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[addr] <= wdata;
  end

  // read samples the array before this edge's write lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (rd) q <= mem[addr];
  end
endmodule

// File: rtl/idata_router.sv
module idata_router
  import idr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int N_SFR  = 13,
  parameter logic [N_SFR*ADDR_W-1:0] SFR_MAP = {
    8'hF0, 8'hE0, 8'hD0, 8'hB8, 8'hB0, 8'hA8, 8'hA0,
    8'h90, 8'h89, 8'h88, 8'h83, 8'h81, 8'h80
  }
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_indirect,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              sfr_sel,
  output logic [ADDR_W-1:0] sfr_addr,
  output logic              sfr_rd,
  output logic              sfr_wr,
  output logic [DATA_W-1:0] sfr_wdata,
  input  logic [DATA_W-1:0] sfr_rdata
);
  localparam int BANK_AW = ADDR_W - 1;
  localparam int N_BANK  = 2;

  dst_e dst;
  logic sfr_hit;
  logic bank_idx;
  logic [DATA_W-1:0] bank_q [N_BANK];

  dst_e              src_q;
  logic              bank_sel_q;
  logic [DATA_W-1:0] sfr_cap_q;
  logic              valid_q;

  idr_decode #(
    .ADDR_W (ADDR_W),
    .N_SFR  (N_SFR),
    .SFR_MAP(SFR_MAP)
  ) u_decode (
    .addr    (acc_addr),
    .indirect(acc_indirect),
    .dst     (dst),
    .sfr_hit (sfr_hit)
  );

  assign bank_idx = acc_addr[ADDR_W-1];

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic here;
    assign here = (dst == DST_RAM) && (bank_idx == b[0]);

    idr_ram_bank #(
      .DATA_W(DATA_W),
      .AW    (BANK_AW)
    ) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .rd   (acc_rd && here),
      .wr   (acc_wr && here),
      .addr (acc_addr[BANK_AW-1:0]),
      .wdata(acc_wdata),
      .q    (bank_q[b])
    );
  end

  // register bus, same cycle as the request
  assign sfr_sel   = sfr_hit && (acc_rd || acc_wr);
  assign sfr_rd    = sfr_hit && acc_rd;
  assign sfr_wr    = sfr_hit && acc_wr;
  assign sfr_addr  = acc_addr;
  assign sfr_wdata = acc_wdata;

  // return path: one register stage for both sources
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      src_q      <= DST_SFR;
      bank_sel_q <= 1'b0;
      sfr_cap_q  <= '0;
    end else begin
      valid_q <= acc_rd;
      if (acc_rd) begin
        src_q      <= dst;
        bank_sel_q <= bank_idx;
        if (dst == DST_SFR) sfr_cap_q <= sfr_hit ? sfr_rdata : '0;
      end
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = (src_q == DST_RAM) ? bank_q[bank_sel_q] : sfr_cap_q;
endmodule

// File: rtl/idr_checker.sv
module idr_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_indirect,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              sfr_sel,
  input logic              sfr_rd,
  input logic              sfr_wr,
  input logic [DATA_W-1:0] sfr_rdata
);
  p_low_never_sfr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_addr[ADDR_W-1] |-> !(sfr_sel || sfr_rd || sfr_wr));

  p_strobe_only_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd || sfr_wr) |-> (!acc_indirect && acc_addr[ADDR_W-1] && sfr_sel));

  p_indirect_no_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_indirect |-> !(sfr_sel || sfr_rd || sfr_wr));

  p_valid_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rd_valid);

  p_no_valid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> !rd_valid);

  p_sfr_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_rd |=> (rd_data == $past(sfr_rdata)));

  p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !acc_indirect && acc_addr[ADDR_W-1] && !sfr_sel) |=> (rd_data == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> $stable(rd_data));
endmodule

bind idata_router idr_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_idr_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_addr    (acc_addr),
  .acc_indirect(acc_indirect),
  .acc_rd      (acc_rd),
  .acc_wr      (acc_wr),
  .rd_data     (rd_data),
  .rd_valid    (rd_valid),
  .sfr_sel     (sfr_sel),
  .sfr_rd      (sfr_rd),
  .sfr_wr      (sfr_wr),
  .sfr_rdata   (sfr_rdata)
);

// File: tb/test_idata_router.sv
module test_idata_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] acc_addr = '0;
  logic       acc_indirect = 1'b0;
  logic       acc_rd = 1'b0;
  logic       acc_wr = 1'b0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic       sfr_sel;
  logic [7:0] sfr_addr;
  logic       sfr_rd;
  logic       sfr_wr;
  logic [7:0] sfr_wdata;
  logic [7:0] sfr_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] ram_m [256];
  logic [7:0] exp_data = '0;
  logic       exp_valid = 1'b0;

  always #2 clk = ~clk;

  idata_router i_idata_router (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_indirect(acc_indirect),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .sfr_sel(sfr_sel), .sfr_addr(sfr_addr), .sfr_rd(sfr_rd),
    .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  function automatic bit is_impl(input logic [7:0] a);
    case (a)
      8'h80, 8'h81, 8'h83, 8'h88, 8'h89, 8'h90, 8'hA0,
      8'hA8, 8'hB0, 8'hB8, 8'hD0, 8'hE0, 8'hF0: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit to_ram(input logic [7:0] a, input logic ind);
    return !a[7] || ind;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // check the previous result, then drive one access; caller is at a negedge
  task automatic access(input logic [7:0] a, input logic ind, input logic rd,
                        input logic wr, input logic [7:0] wd, input logic [7:0] srd);
    bit ram_t, sfr_t;
    chk(rd_valid == exp_valid, "R5 rd_valid", rd_valid, exp_valid);
    chk(rd_data == exp_data, exp_valid ? "R5 rd_data" : "R10 hold", rd_data, exp_data);
    acc_addr = a; acc_indirect = ind; acc_rd = rd; acc_wr = wr;
    acc_wdata = wd; sfr_rdata = srd;
    #1;
    ram_t = to_ram(a, ind);
    sfr_t = !ram_t && is_impl(a);
    if (!a[7])    chk(!(sfr_sel | sfr_rd | sfr_wr), "R1 no bus", sfr_sel, 0);
    else if (ind) chk(!(sfr_sel | sfr_rd | sfr_wr), "R3 no bus", sfr_sel, 0);
    else if (!sfr_t) chk(!(sfr_sel | sfr_rd | sfr_wr), "R7 no bus", sfr_sel, 0);
    else begin
      chk(sfr_sel == (rd | wr), "R2 sfr_sel", sfr_sel, rd | wr);
      chk(sfr_rd == rd && sfr_wr == wr, "R2 strobes", {sfr_rd, sfr_wr}, {rd, wr});
      chk(sfr_addr == a, "R2 sfr_addr", sfr_addr, a);
      if (wr) chk(sfr_wdata == wd, "R2 sfr_wdata", sfr_wdata, wd);
    end
    exp_valid = rd;
    if (rd) begin
      if (ram_t)      exp_data = ram_m[a];   // old value on same-cycle write (R8)
      else if (sfr_t) exp_data = srd;        // R6
      else            exp_data = 8'h00;      // R7
    end
    if (wr && ram_t) ram_m[a] = wd;
    @(negedge clk);
  endtask

  task automatic idle();
    access(8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h1D5EED);
    #10;
    // R9: reset state
    chk(rd_valid == 1'b0, "R9 rd_valid", rd_valid, 0);
    chk(rd_data == 8'h00, "R9 rd_data", rd_data, 0);
    chk(!(sfr_sel | sfr_rd | sfr_wr), "R9 bus idle", sfr_sel, 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);

    // fill both RAM halves: lower by direct, upper by indirect (R1, R3)
    for (int i = 0; i < 128; i++) access(8'(i), 1'b0, 1'b0, 1'b1, 8'(i * 7 + 3), 8'h00);
    for (int i = 128; i < 256; i++) access(8'(i), 1'b1, 1'b0, 1'b1, 8'(i ^ 8'h3C), 8'h00);

    // R1: lower written direct, read indirect
    access(8'h25, 1'b0, 1'b0, 1'b1, 8'hC3, 8'h00);
    access(8'h25, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
    // R3/R4: A0 in both stores
    access(8'hA0, 1'b1, 1'b0, 1'b1, 8'h33, 8'h00);
    access(8'hA0, 1'b0, 1'b0, 1'b1, 8'hEE, 8'h00);
    access(8'hA0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h9D);  // R6
    access(8'hA0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h9D);  // R4 expects 33
    // R7: unimplemented write then read
    access(8'hC5, 1'b0, 1'b0, 1'b1, 8'h77, 8'h00);
    access(8'hC5, 1'b0, 1'b1, 1'b0, 8'h00, 8'hAB);
    access(8'hC5, 1'b1, 1'b1, 1'b0, 8'h00, 8'hAB);  // upper RAM untouched
    // R8: read and write same cycle
    access(8'hF7, 1'b1, 1'b1, 1'b1, 8'h5E, 8'h00);
    access(8'hF7, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
    access(8'h11, 1'b0, 1'b1, 1'b1, 8'h42, 8'h00);
    access(8'h11, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
    // R10: idle cycles hold
    idle(); idle(); idle();

    // constrained random mix
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] a;
      int pick;
      pick = $urandom_range(0, 3);
      if (pick == 0) begin
        case ($urandom_range(0, 3))
          0: a = 8'hA0; 1: a = 8'h81; 2: a = 8'hE0; default: a = 8'hD0;
        endcase
      end else a = 8'($urandom);
      access(a, 1'($urandom), ($urandom_range(0, 2) != 0), 1'($urandom),
             8'($urandom), 8'($urandom));
    end
    idle(); idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule